// File: doc/BRIEF.md
# Extended State Save Sequencer

This block carries out a context-save operation: it copies a selected set of processor state components into a save area in memory. On a start pulse it captures a 64-bit request mask (formed from the low 32 bits of two source registers), a 64-bit enable register, a per-component in-use bitmap, a base address and the mode and control bits that govern faults. The save set is the bitwise AND of the request mask and the enable register. The block then checks for faults in one cycle, before any memory access.

When no fault is found, the block walks the components in a fixed order and writes one 64-bit word per cycle over a simple memory port. A ready-low stall holds the current write. The walk covers the legacy floating-point words, the control/status word, the legacy vector words and then each extended component at its own parameterised offset. It ends with a read-modify-write of the header's state bitmap word. Component contents come from a stub state source with a fixed data pattern.

The controller is a state machine with seven states: IDLE, CHECK, FAULT, SAVE, HDR_RD, HDR_WR and DONE. IDLE goes to CHECK on start. CHECK goes to FAULT on any fault, to SAVE when some slot is enabled, and to HDR_RD otherwise. SAVE stays in place for each word and each further enabled slot, and goes to HDR_RD after the last word of the last enabled slot. HDR_RD goes to HDR_WR once the read is accepted. HDR_WR goes to DONE once the write is accepted. FAULT and DONE each return to IDLE after one cycle.

Top module: `ctx_save_seq`

## Requirements
- R1: The save set is `{req_hi_i[31:0], req_lo_i[31:0]} & feat_en_i`, captured on start. Bits 63:32 of both request inputs have no effect. Component i is written if and only if bit i of the save set is 1.
- R2: Component 0 writes 3 words at byte offsets 0, 8 and 16 from the base. The vector part of component 1 writes 4 words at offsets 160, 168, 176 and 184. Every memory address is a multiple of 8.
- R3: The control/status word goes to offset 24 when save-set bit 1 or bit 2 is 1, including the case where only bit 2 is 1. Its value is 64'h0000FFFF_00001F80: the mask word is in bits 63:32 and the control word in bits 31:0.
- R4: Each extended component c (2 to 5 by default) writes its parameterised word count starting at its parameterised offset: c2 writes 4 words at 576, c3 writes 2 at 640, c4 writes 3 at 704 and c5 writes 2 at 768.
- R5: Writes happen in this order: component 0, the control/status word, the vector words, then extended components in ascending order, then the header. A memory port never asserts read and write together. While `mem_rdy_i` is low, the address and data of a pending write are held.
- R6: The header word at offset 512 is read, and the value written back is `(old & ~save) | (inuse & save)`. No other header word is touched, and no write ever falls within offsets 464 to 511.
- R7: A fault raises `fault_o` for exactly one cycle, two cycles after the start edge. The fault code priority is: invalid-opcode = 1, then device-not-available = 2, then general-protection = 3.
- R8: Invalid-opcode is raised when `feat_ok_i` is 0, `os_en_i` is 0 or `lock_i` is 1. Device-not-available is raised when `task_sw_i` is 1. General-protection is raised when base bits 5:0 are not zero, or when `mode64_i` is 1 and base bits 63:47 are not all equal. A faulting operation writes nothing to memory.
- R9: `done_o` pulses for one cycle, one cycle after the header write is accepted. `busy_o` is low in the cycle after that pulse.
- R10: A start pulse while busy is ignored. After reset the block is idle, with busy, done, fault and both memory strobes low.
- R11: Word k of component c, as supplied by the state source, is `{16'hA5C0, c[7:0], k[7:0], 32'h5A5A5A5A}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| req_lo_i | input | 64 | Low request register; only bits 31:0 are used |
| req_hi_i | input | 64 | High request register; only bits 31:0 are used |
| feat_en_i | input | 64 | Enabled-feature register |
| inuse_i | input | 64 | Per-component in-use bitmap |
| base_i | input | 64 | Byte base address of the save area |
| mode64_i | input | 1 | 64-bit mode; enables the canonical-address check |
| feat_ok_i | input | 1 | Feature-present indication |
| os_en_i | input | 1 | OS-enable control bit (control bit 18) |
| task_sw_i | input | 1 | Task-switched control bit (control bit 3) |
| lock_i | input | 1 | Lock prefix present |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_code_o | output | 2 | Fault code, valid with fault_o |
| mem_addr_o | output | 64 | Memory byte address |
| mem_wdata_o | output | 64 | Memory write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | 64 | Read data, valid when mem_rdy_i is high |
| mem_rdy_i | input | 1 | Memory ready; low stalls the access |

## Verification
The assertions assume that the memory answers a read in the same cycle that `mem_rdy_i` is high, and that the base address plus the largest offset does not wrap past 2^64. The reserved-range check depends on that second condition. The bench keeps to these by choosing base addresses with the top 17 bits clear, or with one high bit set only for the non-canonical cases. Its memory model returns the header value combinationally. It drives `mem_rdy_i` at the falling edge, so ready only changes away from the sampling edge.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FAULT,
        ST_SAVE,
        ST_HDR_RD,
        ST_HDR_WR,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_OPC  = 2'd1,
        FLT_DEV  = 2'd2,
        FLT_PROT = 2'd3
    } fault_e;

    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned X87_OFS    = 0;
    localparam int unsigned CSR_OFS    = 24;
    localparam int unsigned VEC_OFS    = 160;
    localparam int unsigned HDR_OFS    = 512;
    localparam int unsigned RSV_LO     = 464;
    localparam int unsigned RSV_HI     = 511;
    localparam int unsigned ALIGN_BITS = 6;

    localparam logic [31:0] CSR_CTRL_VAL = 32'h0000_1F80;
    localparam logic [31:0] CSR_MASK_VAL = 32'h0000_FFFF;

endpackage

// File: rtl/ctx_fault_chk.sv
module ctx_fault_chk
    import ctx_save_pkg::*;
#(
    parameter int VA_BITS = 48
) (
    input  logic        feat_ok,
    input  logic        os_en,
    input  logic        task_sw,
    input  logic        lock,
    input  logic        mode64,
    input  logic [63:0] base,
    output fault_e      code
);

    localparam int HI_W = 64 - (VA_BITS - 1);

    logic [HI_W-1:0] upper;
    logic            noncanon;
    logic            misaligned;

    always_comb begin
        upper      = base[63:VA_BITS-1];
        noncanon   = mode64 && !((&upper) || !(|upper));
        misaligned = |base[ALIGN_BITS-1:0];
        if (!feat_ok || !os_en || lock) begin
            code = FLT_OPC;
        end else if (task_sw) begin
            code = FLT_DEV;
        end else if (misaligned || noncanon) begin
            code = FLT_PROT;
        end else begin
            code = FLT_NONE;
        end
    end

endmodule

// File: rtl/ctx_slot_map.sv
module ctx_slot_map
    import ctx_save_pkg::*;
#(
    parameter int                       NUM_COMP  = 6,
    parameter int                       X87_WORDS = 3,
    parameter int                       VEC_WORDS = 4,
    parameter logic [NUM_COMP*16-1:0]   COMP_OFS  = '0,
    parameter logic [NUM_COMP*16-1:0]   COMP_WRDS = '0,
    localparam int                      NSLOT     = NUM_COMP + 1,
    localparam int                      SLOT_W    = $clog2(NSLOT)
) (
    input  logic [NUM_COMP-1:0] save_set,
    input  logic [SLOT_W-1:0]   cur_slot,
    output logic [SLOT_W-1:0]   first_slot,
    output logic                first_vld,
    output logic [SLOT_W-1:0]   next_slot,
    output logic                next_vld,
    output logic [15:0]         slot_ofs,
    output logic [15:0]         slot_words,
    output logic [7:0]          slot_comp,
    output logic                slot_is_csr
);

    logic [NSLOT-1:0] slot_en;

    // Slot 0: x87, slot 1: control/status word, slot 2: vector words,
    // slot s >= 3: extended component s-1.
    assign slot_en[0] = save_set[0];
    assign slot_en[1] = save_set[1] | save_set[2];
    assign slot_en[2] = save_set[1];

    generate
        for (genvar s = 3; s < NSLOT; s++) begin : g_ext_en
            assign slot_en[s] = save_set[s-1];
        end
    endgenerate

    always_comb begin
        first_slot = '0;
        first_vld  = 1'b0;
        next_slot  = '0;
        next_vld   = 1'b0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slot_en[s]) begin
                first_slot = SLOT_W'(s);
                first_vld  = 1'b1;
                if (s > int'(cur_slot)) begin
                    next_slot = SLOT_W'(s);
                    next_vld  = 1'b1;
                end
            end
        end
    end

    always_comb begin
        int ci;
        ci          = int'(cur_slot) - 1;
        slot_is_csr = 1'b0;
        slot_ofs    = '0;
        slot_words  = 16'd1;
        slot_comp   = '0;
        if (cur_slot == SLOT_W'(0)) begin
            slot_ofs   = 16'(X87_OFS);
            slot_words = 16'(X87_WORDS);
            slot_comp  = 8'd0;
        end else if (cur_slot == SLOT_W'(1)) begin
            slot_ofs    = 16'(CSR_OFS);
            slot_words  = 16'd1;
            slot_is_csr = 1'b1;
        end else if (cur_slot == SLOT_W'(2)) begin
            slot_ofs   = 16'(VEC_OFS);
            slot_words = 16'(VEC_WORDS);
            slot_comp  = 8'd1;
        end else if (ci < NUM_COMP) begin
            slot_ofs   = COMP_OFS[16*ci +: 16];
            slot_words = COMP_WRDS[16*ci +: 16];
            slot_comp  = 8'(ci);
        end
    end

endmodule

// File: rtl/ctx_state_stub.sv
module ctx_state_stub
    import ctx_save_pkg::*;
(
    input  logic [7:0]  comp,
    input  logic [7:0]  word_idx,
    input  logic        is_csr,
    output logic [63:0] data
);

    always_comb begin
        if (is_csr) begin
            data = {CSR_MASK_VAL, CSR_CTRL_VAL};
        end else begin
            data = {16'hA5C0, comp, word_idx, 32'h5A5A_5A5A};
        end
    end

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
    import ctx_save_pkg::*;
#(
    parameter int                     NUM_COMP  = 6,
    parameter int                     X87_WORDS = 3,
    parameter int                     VEC_WORDS = 4,
    parameter int                     VA_BITS   = 48,
    parameter logic [NUM_COMP*16-1:0] COMP_OFS  =
        {16'd768, 16'd704, 16'd640, 16'd576, 16'd0, 16'd0},
    parameter logic [NUM_COMP*16-1:0] COMP_WRDS =
        {16'd2, 16'd3, 16'd2, 16'd4, 16'd0, 16'd0}
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic [63:0] req_lo_i,
    input  logic [63:0] req_hi_i,
    input  logic [63:0] feat_en_i,
    input  logic [63:0] inuse_i,
    input  logic [63:0] base_i,
    input  logic        mode64_i,
    input  logic        feat_ok_i,
    input  logic        os_en_i,
    input  logic        task_sw_i,
    input  logic        lock_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        fault_o,
    output logic [1:0]  fault_code_o,
    output logic [63:0] mem_addr_o,
    output logic [63:0] mem_wdata_o,
    output logic        mem_we_o,
    output logic        mem_re_o,
    input  logic [63:0] mem_rdata_i,
    input  logic        mem_rdy_i
);

    localparam int NSLOT  = NUM_COMP + 1;
    localparam int SLOT_W = $clog2(NSLOT);

    seq_state_e        state_q, state_d;
    logic [63:0]       save_q;
    logic [63:0]       inuse_q;
    logic [63:0]       base_q;
    logic [63:0]       old_q;
    logic              mode64_q, feat_ok_q, os_en_q, task_sw_q, lock_q;
    fault_e            code_q;
    fault_e            code_now;
    logic [SLOT_W-1:0] slot_q;
    logic [15:0]       widx_q;

    logic [SLOT_W-1:0] first_slot, next_slot;
    logic              first_vld, next_vld;
    logic [15:0]       slot_ofs, slot_words;
    logic [7:0]        slot_comp;
    logic              slot_is_csr;
    logic [63:0]       stub_data;
    logic              last_word;
    logic [63:0]       req_mask;
    logic              unused_req_hi;

    assign req_mask      = {req_hi_i[31:0], req_lo_i[31:0]};
    assign unused_req_hi = ^{req_hi_i[63:32], req_lo_i[63:32]};
    assign last_word     = (widx_q == slot_words - 16'd1);

    ctx_fault_chk #(
        .VA_BITS (VA_BITS)
    ) u_fault (
        .feat_ok (feat_ok_q),
        .os_en   (os_en_q),
        .task_sw (task_sw_q),
        .lock    (lock_q),
        .mode64  (mode64_q),
        .base    (base_q),
        .code    (code_now)
    );

    ctx_slot_map #(
        .NUM_COMP  (NUM_COMP),
        .X87_WORDS (X87_WORDS),
        .VEC_WORDS (VEC_WORDS),
        .COMP_OFS  (COMP_OFS),
        .COMP_WRDS (COMP_WRDS)
    ) u_map (
        .save_set    (save_q[NUM_COMP-1:0]),
        .cur_slot    (slot_q),
        .first_slot  (first_slot),
        .first_vld   (first_vld),
        .next_slot   (next_slot),
        .next_vld    (next_vld),
        .slot_ofs    (slot_ofs),
        .slot_words  (slot_words),
        .slot_comp   (slot_comp),
        .slot_is_csr (slot_is_csr)
    );

    ctx_state_stub u_stub (
        .comp     (slot_comp),
        .word_idx (widx_q[7:0]),
        .is_csr   (slot_is_csr),
        .data     (stub_data)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (code_now != FLT_NONE) state_d = ST_FAULT;
                else if (first_vld)       state_d = ST_SAVE;
                else                      state_d = ST_HDR_RD;
            end
            ST_FAULT: state_d = ST_IDLE;
            ST_SAVE: begin
                if (mem_rdy_i && last_word && !next_vld) state_d = ST_HDR_RD;
            end
            ST_HDR_RD: begin
                if (mem_rdy_i) state_d = ST_HDR_WR;
            end
            ST_HDR_WR: begin
                if (mem_rdy_i) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Operation context and walk counters
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            save_q    <= '0;
            inuse_q   <= '0;
            base_q    <= '0;
            old_q     <= '0;
            mode64_q  <= 1'b0;
            feat_ok_q <= 1'b0;
            os_en_q   <= 1'b0;
            task_sw_q <= 1'b0;
            lock_q    <= 1'b0;
            code_q    <= FLT_NONE;
            slot_q    <= '0;
            widx_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        save_q    <= req_mask & feat_en_i;
                        inuse_q   <= inuse_i;
                        base_q    <= base_i;
                        mode64_q  <= mode64_i;
                        feat_ok_q <= feat_ok_i;
                        os_en_q   <= os_en_i;
                        task_sw_q <= task_sw_i;
                        lock_q    <= lock_i;
                    end
                end
                ST_CHECK: begin
                    code_q <= code_now;
                    slot_q <= first_slot;
                    widx_q <= '0;
                end
                ST_SAVE: begin
                    if (mem_rdy_i) begin
                        if (last_word) begin
                            slot_q <= next_slot;
                            widx_q <= '0;
                        end else begin
                            widx_q <= widx_q + 16'd1;
                        end
                    end
                end
                ST_HDR_RD: begin
                    if (mem_rdy_i) old_q <= mem_rdata_i;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = 1'b0;
        fault_o      = 1'b0;
        fault_code_o = FLT_NONE;
        mem_we_o     = 1'b0;
        mem_re_o     = 1'b0;
        mem_addr_o   = '0;
        mem_wdata_o  = '0;
        unique case (state_q)
            ST_FAULT: begin
                fault_o      = 1'b1;
                fault_code_o = code_q;
            end
            ST_SAVE: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = base_q + {48'b0, slot_ofs} + {45'b0, widx_q, 3'b000};
                mem_wdata_o = stub_data;
            end
            ST_HDR_RD: begin
                mem_re_o   = 1'b1;
                mem_addr_o = base_q + 64'(HDR_OFS);
            end
            ST_HDR_WR: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = base_q + 64'(HDR_OFS);
                mem_wdata_o = (old_q & ~save_q) | (inuse_q & save_q);
            end
            ST_DONE: done_o = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ctx_save_sva.sv
module ctx_save_sva
    import ctx_save_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        fault_o,
    input logic [1:0]  fault_code_o,
    input logic [63:0] mem_addr_o,
    input logic [63:0] mem_wdata_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic        mem_rdy_i,
    input logic [63:0] base_q
);

    logic        wrote_q;
    logic [63:0] rel_addr;

    assign rel_addr = mem_addr_o - base_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                    wrote_q <= 1'b0;
        else if (!busy_o)               wrote_q <= 1'b0;
        else if (mem_we_o && mem_rdy_i) wrote_q <= 1'b1;
    end

    p_word_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o || mem_re_o) |-> (mem_addr_o[2:0] == 3'b000));

    p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_we_o && mem_re_o));

    p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && !mem_rdy_i) |=>
            (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    p_reserved_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> !((rel_addr >= 64'(RSV_LO)) && (rel_addr <= 64'(RSV_HI))));

    p_fault_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> !fault_o);

    p_fault_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (fault_code_o != 2'd0));

    p_fault_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> !wrote_q);

    p_done_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!busy_o && !done_o));

    p_start_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    p_excl_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && fault_o));

endmodule

bind ctx_save_seq ctx_save_sva u_sva (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .mem_rdy_i    (mem_rdy_i),
    .base_q       (base_q)
);

// File: tb/ctx_save_seq_tb.sv
module ctx_save_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] req_lo_i = '0, req_hi_i = '0, feat_en_i = '0, inuse_i = '0, base_i = '0;
    logic        mode64_i = 1'b0, feat_ok_i = 1'b1, os_en_i = 1'b1, task_sw_i = 1'b0, lock_i = 1'b0;
    logic        busy_o, done_o, fault_o, mem_we_o, mem_re_o;
    logic [1:0]  fault_code_o;
    logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_rdy_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int wd_cnt = 0;
    bit stall_en = 1'b0;

    logic [63:0] hdr_old = '0;
    logic [63:0] cur_base = '0;
    logic [63:0] log_a [64];
    logic [63:0] log_d [64];
    int          log_n = 0;
    logic [63:0] exp_a [64];
    logic [63:0] exp_d [64];
    int          exp_n = 0;

    localparam int          OFS_T [6] = '{0, 0, 576, 640, 704, 768};
    localparam int          WRD_T [6] = '{0, 0, 4, 2, 3, 2};
    localparam logic [63:0] CSR_W     = 64'h0000FFFF_00001F80;

    always #5 clk = ~clk;

    ctx_save_seq dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start_i),
        .req_lo_i     (req_lo_i),
        .req_hi_i     (req_hi_i),
        .feat_en_i    (feat_en_i),
        .inuse_i      (inuse_i),
        .base_i       (base_i),
        .mode64_i     (mode64_i),
        .feat_ok_i    (feat_ok_i),
        .os_en_i      (os_en_i),
        .task_sw_i    (task_sw_i),
        .lock_i       (lock_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .fault_o      (fault_o),
        .fault_code_o (fault_code_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_we_o     (mem_we_o),
        .mem_re_o     (mem_re_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rdy_i    (mem_rdy_i)
    );

    assign mem_rdata_i = (mem_addr_o == cur_base + 64'd512) ? hdr_old : 64'hBAD0_BAD0_BAD0_BAD0;

    // Memory model: choose ready for the coming edge, then log accepted writes
    always @(negedge clk) begin
        mem_rdy_i = stall_en ? (($urandom % 3) != 0) : 1'b1;
        if (mem_we_o && mem_rdy_i && log_n < 64) begin
            log_a[log_n] = mem_addr_o;
            log_d[log_n] = mem_wdata_o;
            log_n++;
        end
    end

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 100000) begin
            errors++;
            $display("FAIL R9 watchdog act=%0d exp<=%0d", wd_cnt, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] wd(input int c, input int k);
        return {16'hA5C0, 8'(c), 8'(k), 32'h5A5A_5A5A};
    endfunction

    function automatic logic [1:0] exp_fault(input logic [63:0] base, input bit m64,
                                             input bit feat, input bit os, input bit ts, input bit lk);
        logic [16:0] up;
        up = base[63:47];
        if (!feat || !os || lk) return 2'd1;
        if (ts) return 2'd2;
        if (base[5:0] != 6'd0 || (m64 && !((&up) || (up == 17'd0)))) return 2'd3;
        return 2'd0;
    endfunction

    task automatic push(input logic [63:0] a, input logic [63:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    // Expected write list from R1..R4 and R11, in the R5 order
    task automatic build_exp(input logic [63:0] bm, input logic [63:0] base);
        exp_n = 0;
        if (bm[0]) for (int k = 0; k < 3; k++) push(base + 64'(8 * k), wd(0, k));
        if (bm[1] || bm[2]) push(base + 64'd24, CSR_W);
        if (bm[1]) for (int k = 0; k < 4; k++) push(base + 64'(160 + 8 * k), wd(1, k));
        for (int c = 2; c < 6; c++)
            if (bm[c]) for (int k = 0; k < WRD_T[c]; k++) push(base + 64'(OFS_T[c] + 8 * k), wd(c, k));
    endtask

    task automatic do_op(input logic [63:0] lo, input logic [63:0] hi, input logic [63:0] en,
                         input logic [63:0] inuse, input logic [63:0] base, input logic [63:0] old,
                         input bit m64, input bit feat, input bit os, input bit ts, input bit lk,
                         input bit mid);
        logic [63:0] bm;
        logic [1:0]  ef;
        int          cyc;
        bit          seen_done, seen_flt;
        logic [1:0]  code;
        @(negedge clk);
        req_lo_i = lo; req_hi_i = hi; feat_en_i = en; inuse_i = inuse; base_i = base;
        mode64_i = m64; feat_ok_i = feat; os_en_i = os; task_sw_i = ts; lock_i = lk;
        hdr_old = old; cur_base = base; log_n = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        req_lo_i = ~lo; req_hi_i = ~hi; feat_en_i = ~en; inuse_i = ~inuse; base_i = '0;
        bm = {hi[31:0], lo[31:0]} & en;
        ef = exp_fault(base, m64, feat, os, ts, lk);
        cyc = 0; seen_done = 0; seen_flt = 0; code = '0;
        while (!seen_done && !seen_flt && cyc < 500) begin
            if (done_o) seen_done = 1;
            else if (fault_o) begin seen_flt = 1; code = fault_code_o; end
            else begin
                @(negedge clk);
                cyc++;
                if (mid && cyc == 3) begin
                    start_i = 1'b1; req_lo_i = '1; req_hi_i = '1; feat_en_i = '1; base_i = 64'h40;
                end
                if (mid && cyc == 4) start_i = 1'b0;
            end
        end
        if (ef != 2'd0) begin
            chk(seen_flt && code == ef, "R7", "fault code priority", {62'd0, code}, {62'd0, ef});
            chk(cyc == 1, "R7", "fault timing", 64'(cyc), 64'd1);
            chk(log_n == 0, "R8", "writes on fault", 64'(log_n), 64'd0);
            @(negedge clk);
            chk(!fault_o && !busy_o, "R7", "fault pulse width", {63'd0, fault_o}, 64'd0);
        end else begin
            chk(seen_done && !seen_flt, "R9", "completion", {63'd0, seen_done}, 64'd1);
            build_exp(bm, base);
            chk(log_n == exp_n + 1, "R1", "write count", 64'(log_n), 64'(exp_n + 1));
            for (int i = 0; i < exp_n && i < log_n; i++)
                chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], "R5",
                    $sformatf("write %0d addr/data (R2 R3 R4 R11)", i), log_a[i] ^ log_d[i],
                    exp_a[i] ^ exp_d[i]);
            if (log_n > 0)
                chk(log_a[log_n-1] == base + 64'd512 &&
                    log_d[log_n-1] == ((old & ~bm) | (inuse & bm)), "R6", "header merge",
                    log_d[log_n-1], (old & ~bm) | (inuse & bm));
            @(negedge clk);
            chk(!done_o && !busy_o, "R9", "done pulse width", {63'd0, done_o}, 64'd0);
        end
        req_lo_i = '0; req_hi_i = '0; feat_en_i = '0; start_i = 1'b0;
    endtask

    initial begin
        logic [63:0] b;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!busy_o && !mem_we_o && !mem_re_o && !done_o && !fault_o, "R10", "reset idle",
            {59'd0, busy_o, mem_we_o, mem_re_o, done_o, fault_o}, 64'd0);

        // Full set, no stall (R2 R3 R4 R5 R6)
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 64'h15,
              64'h0000_1000, 64'hF0F0_0000_0000_00AA, 1, 1, 1, 0, 0, 0);
        // Only bit 2: control word without vector words (R3)
        do_op(64'h4, 64'h0, 64'hFF, 64'h4, 64'h0000_2000, 64'h0, 1, 1, 1, 0, 0, 0);
        // Upper halves only: nothing saved, header unchanged (R1)
        do_op(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
              64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_3000, 64'h1234_5678_9ABC_DEF0, 1, 1, 1, 0, 0, 0);
        // Enable register masks request (R1)
        do_op(64'h3F, 64'h0, 64'h28, 64'h0, 64'h0000_4000, 64'hFF, 0, 1, 1, 0, 0, 0);
        // Faults and priority (R7 R8)
        do_op(64'hFF, 0, 64'hFF, 0, 64'h0000_5000, 0, 1, 0, 1, 0, 0, 0);
        do_op(64'hFF, 0, 64'hFF, 0, 64'h0000_5001, 0, 1, 1, 1, 1, 1, 0);
        do_op(64'hFF, 0, 64'hFF, 0, 64'h0000_5000, 0, 1, 1, 0, 0, 0, 0);
        do_op(64'hFF, 0, 64'hFF, 0, 64'h0000_5020, 0, 1, 1, 1, 1, 0, 0);
        do_op(64'hFF, 0, 64'hFF, 0, 64'h0000_5020, 0, 1, 1, 1, 0, 0, 0);
        do_op(64'hFF, 0, 64'hFF, 0, 64'h0001_0000_0000_0040, 0, 1, 1, 1, 0, 0, 0);
        // Same high bit outside 64-bit mode: no fault (R8)
        do_op(64'h3, 0, 64'hFF, 64'h3, 64'h0001_0000_0000_0040, 64'h8, 0, 1, 1, 0, 0, 0);
        // Stalls hold the access (R5)
        stall_en = 1'b1;
        do_op(64'h3F, 0, 64'hFF, 64'h2A, 64'h0000_6000, 64'h1, 1, 1, 1, 0, 0, 0);
        stall_en = 1'b0;
        // Start while busy is ignored (R10)
        do_op(64'h3D, 0, 64'hFF, 64'h3C, 64'h0000_7000, 64'h0, 1, 1, 1, 0, 0, 1);

        // Constrained random mix
        for (int n = 0; n < 40; n++) begin
            int sel;
            bit f_feat, f_ts;
            sel    = int'($urandom % 8);
            b      = {17'd0, 41'({$urandom, $urandom}), 6'd0};
            f_feat = (sel != 0);
            f_ts   = (sel == 1);
            if (sel == 2) b[5:0] = 6'($urandom) | 6'd1;
            stall_en = ($urandom % 2) == 1;
            do_op({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  {$urandom, $urandom}, b, {$urandom, $urandom},
                  ($urandom % 2) == 1, f_feat, 1'b1, f_ts, 1'b0, 1'b0);
        end
        stall_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule